// File: doc/BRIEF.md
# Single-Cycle Load-Store Integer Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. It holds its own instruction memory and data memory as word arrays. While reset is held, a preload port fills both arrays. Once reset is released, execution starts at byte address 0. In each cycle the core fetches one 32-bit word and splits it into fields. It reads two operands from a 32-entry register file, computes a result, reads or writes the data array if needed, and commits the result at the next rising edge.

The core implements ten operations: register add, subtract and signed set-less-than, and immediate add, set-less-than, AND, OR, load-upper, word load and word store. A full 32-bit constant is built from two instructions, an upper load followed by an OR immediate. A test environment observes the core through three outputs: a register peek port, a store strobe that exposes every data write, and the program counter.

Top module: `rcore`

## Requirements
- R1: Register 0 always reads as zero through the peek port and as an operand. An instruction whose destination is register 0 changes nothing.
- R2: Opcode 0 is register format: op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0]. funct 32 writes rs+rt to rd and funct 34 writes rs-rt to rd.
- R3: Opcode 8 adds the sign-extended 16-bit immediate (bits 15:0) to rs and writes the sum to rt.
- R4: funct 42 (register format) writes 1 to rd when rs < rt as signed values, else 0. Opcode 10 makes the same signed comparison of rs against the sign-extended immediate and writes rt.
- R5: Opcode 12 writes rs AND the zero-extended immediate to rt. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R6: Opcode 15 writes the immediate into bits 31:16 of rt and zero into bits 15:0.
- R7: Opcode 35 loads into rt the data word at the effective byte address, which is rs plus the sign-extended immediate. Address bits 1:0 are ignored, so word k sits at byte address 4k.
- R8: Opcode 43 writes rt to the data word at the effective address. During that instruction's cycle, st_en is high, st_addr shows the effective address and st_data shows the stored value. A later load returns the stored word.
- R9: An unknown opcode, or an unknown funct under opcode 0, writes no register and no memory, and st_en stays low.
- R10: While rst_n is low, pc_o is 0, st_en is low and preload writes are accepted. After release, pc_o advances by 4 on every clock and preload writes are ignored.
- R11: A register result is visible to the very next instruction and to the peek port after the clock edge that ends its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also enables preload |
| pre_we | input | 1 | Preload write strobe, used only in reset |
| pre_sel | input | 1 | Preload target: 0 instruction array, 1 data array |
| pre_addr | input | AW | Preload word index |
| pre_wdata | input | 32 | Preload word |
| peek_reg | input | 5 | Register index to observe |
| peek_data | output | 32 | Contents of the observed register |
| pc_o | output | 32 | Byte address of the instruction now executing |
| st_en | output | 1 | High during a store instruction |
| st_addr | output | 32 | Effective byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
A corrupted register value is not visible when it is written; it appears only when a later instruction consumes it or the peek port selects it. Each scenario therefore ends with peeks of every register it touched, taken a fixed number of cycles after release. A wrong program counter or a misdecoded store shows in the same cycle on pc_o and the store strobe. A wrong load or store address, including mishandled low address bits, shows one instruction later through the loaded value. Mistakes in sign extension and signed comparison are exposed by negative operands.

// File: rtl/rcore.sv
module rcore #(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic          pre_sel,
  input  logic [AW-1:0] pre_addr,
  input  logic [31:0]   pre_wdata,
  input  logic [4:0]    peek_reg,
  output logic [31:0]   peek_data,
  output logic [31:0]   pc_o,
  output logic          st_en,
  output logic [31:0]   st_addr,
  output logic [31:0]   st_data
);
  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  logic [31:0] rf   [32];
  logic [31:0] pc, instr, a, b, simm, zimm, ea, res;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, dst;
  logic [15:0] imm;
  logic        we, st, rf_we;

  assign instr = imem[pc[AW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign imm   = instr[15:0];
  assign simm  = {{16{imm[15]}}, imm};
  assign zimm  = {16'h0, imm};

  assign a = (rs == 5'd0) ? 32'h0 : rf[rs];
  assign b = (rt == 5'd0) ? 32'h0 : rf[rt];
  assign peek_data = (peek_reg == 5'd0) ? 32'h0 : rf[peek_reg];

  assign ea = a + simm;

  always_comb begin
    res = 32'h0;
    dst = rt;
    we  = 1'b0;
    st  = 1'b0;
    case (op)
      6'd0: begin
        dst = rd;
        case (funct)
          6'd32: begin res = a + b; we = 1'b1; end
          6'd34: begin res = a - b; we = 1'b1; end
          6'd42: begin res = {31'h0, $signed(a) < $signed(b)}; we = 1'b1; end
          default: ;
        endcase
      end
      6'd8:  begin res = a + simm; we = 1'b1; end
      6'd10: begin res = {31'h0, $signed(a) < $signed(simm)}; we = 1'b1; end
      6'd12: begin res = a & zimm; we = 1'b1; end
      6'd13: begin res = a | zimm; we = 1'b1; end
      6'd15: begin res = {imm, 16'h0}; we = 1'b1; end
      6'd35: begin res = dmem[ea[AW+1:2]]; we = 1'b1; end
      6'd43: st = 1'b1;
      default: ;
    endcase
  end

  assign rf_we   = rst_n && we && (dst != 5'd0);
  assign st_en   = rst_n && st;
  assign st_addr = ea;
  assign st_data = b;
  assign pc_o    = pc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc <= 32'h0;
    else        pc <= pc + 32'd4;

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'h0;
    end else if (rf_we) begin
      rf[dst] <= res;
    end

  always_ff @(posedge clk)
    if (!rst_n && pre_we && !pre_sel) imem[pre_addr] <= pre_wdata;

  always_ff @(posedge clk)
    if (!rst_n && pre_we && pre_sel) dmem[pre_addr] <= pre_wdata;
    else if (st_en)                  dmem[ea[AW+1:2]] <= b;
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_o,
  input logic [4:0]  peek_reg,
  input logic [31:0] peek_data,
  input logic        st_en,
  input logic        rf_we
);
  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_o == $past(pc_o) + 32'd4);

  a_r10_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  a_r1_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    peek_reg == 5'd0 |-> peek_data == 32'h0);

  a_r11_rf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_we |=> (!$stable(peek_reg) || $stable(peek_data)));

  always @(posedge clk)
    a_r10_no_store_in_reset: assert (rst_n || !st_en);
endmodule

bind rcore rcore_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .peek_reg(peek_reg),
  .peek_data(peek_data), .st_en(st_en), .rf_we(rf_we)
);

// File: tb/rcore_tb.sv
module rcore_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, pre_we = 0, pre_sel = 0;
  logic [AW-1:0] pre_addr = '0;
  logic [31:0] pre_wdata = '0;
  logic [4:0] peek_reg = '0;
  logic [31:0] peek_data, pc_o, st_addr, st_data;
  logic st_en;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcore u_dut (.*);

  function automatic logic [31:0] rt_(input int rs, rt, rd, fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] it_(input int op, rs, rt, imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put(input logic sel, input int idx, input logic [31:0] w);
    pre_we = 1; pre_sel = sel; pre_addr = idx[AW-1:0]; pre_wdata = w;
    @(negedge clk);
    pre_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 16; i++) put(0, i, 32'h0);
  endtask

  task automatic go(input int n);
    rst_n = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input string req, input int r, input logic [31:0] exp);
    peek_reg = r[4:0];
    #1;
    chk(req, peek_data, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 pc in reset", pc_o, 32'h0);
    chk("R10 st_en in reset", {31'h0, st_en}, 32'h0);
    put(0, 0, it_(8, 0, 3, 1));
    go(1);
    chk("R10 pc after 1", pc_o, 32'd4);
    put(0, 5, it_(8, 0, 7, 99));
    repeat (2) @(negedge clk);
    chk("R10 pc after 4", pc_o, 32'd16);
    repeat (4) @(negedge clk);
    peek("R10 preload ignored while running", 7, 32'h0);
    peek("R11 first instr result", 3, 32'd1);
  endtask

  task automatic t_arith();
    do_reset();
    put(0, 0, it_(8, 0, 1, 7));
    put(0, 1, it_(8, 0, 2, -3));
    put(0, 2, rt_(1, 2, 3, 32));
    put(0, 3, rt_(1, 2, 4, 34));
    put(0, 4, rt_(2, 1, 5, 34));
    go(6);
    peek("R3 addi pos", 1, 32'd7);
    peek("R3 addi neg", 2, 32'hFFFF_FFFD);
    peek("R2 add", 3, 32'd4);
    peek("R2 sub", 4, 32'd10);
    peek("R2 sub neg", 5, 32'hFFFF_FFF6);
  endtask

  task automatic t_cmp();
    do_reset();
    put(0, 0, it_(8, 0, 1, 7));
    put(0, 1, it_(8, 0, 2, -3));
    put(0, 2, rt_(2, 1, 6, 42));
    put(0, 3, rt_(1, 2, 7, 42));
    put(0, 4, it_(10, 2, 8, -1));
    put(0, 5, it_(10, 1, 9, 7));
    go(7);
    peek("R4 slt neg<pos", 6, 32'd1);
    peek("R4 slt pos<neg", 7, 32'd0);
    peek("R4 slti -3<-1", 8, 32'd1);
    peek("R4 slti 7<7", 9, 32'd0);
  endtask

  task automatic t_logic();
    do_reset();
    put(0, 0, it_(8, 0, 1, -1));
    put(0, 1, it_(12, 1, 2, 16'h8001));
    put(0, 2, it_(13, 0, 3, 16'hF0F0));
    put(0, 3, it_(15, 0, 4, 16'hABCD));
    put(0, 4, it_(13, 4, 5, 16'h1234));
    go(6);
    peek("R5 andi zero-ext", 2, 32'h0000_8001);
    peek("R5 ori zero-ext", 3, 32'h0000_F0F0);
    peek("R6 lui", 4, 32'hABCD_0000);
    peek("R6 lui+ori const", 5, 32'hABCD_1234);
  endtask

  task automatic t_mem();
    do_reset();
    put(1, 1, 32'h0000_0055);
    put(1, 2, 32'h1122_3344);
    put(1, 3, 32'hCAFE_F00D);
    put(1, 6, 32'h0);
    put(0, 0, it_(8, 0, 1, 8));
    put(0, 1, it_(35, 1, 2, 0));
    put(0, 2, it_(35, 1, 3, 6));
    put(0, 3, it_(35, 1, 4, -4));
    put(0, 4, it_(43, 1, 2, 16));
    put(0, 5, it_(35, 1, 5, 16));
    go(3);
    chk("R8 no store on load", {31'h0, st_en}, 32'h0);
    @(negedge clk);
    chk("R8 st_en", {31'h0, st_en}, 32'h1);
    chk("R8 st_addr", st_addr, 32'd24);
    chk("R8 st_data", st_data, 32'h1122_3344);
    repeat (2) @(negedge clk);
    peek("R7 lw aligned", 2, 32'h1122_3344);
    peek("R7 lw low bits ignored", 3, 32'hCAFE_F00D);
    peek("R7 lw neg offset", 4, 32'h0000_0055);
    peek("R8 store then load", 5, 32'h1122_3344);
  endtask

  task automatic t_zero();
    do_reset();
    put(0, 0, it_(8, 0, 0, 5));
    put(0, 1, rt_(0, 0, 1, 32));
    put(0, 2, it_(8, 0, 2, 9));
    put(0, 3, rt_(0, 2, 3, 32));
    go(5);
    peek("R1 reg0 stays zero", 0, 32'h0);
    peek("R1 reg0 operand zero", 1, 32'h0);
    peek("R1 reg0 as rs", 3, 32'd9);
  endtask

  task automatic t_nop();
    int seen = 0;
    do_reset();
    put(0, 0, it_(8, 0, 1, 3));
    put(0, 1, it_(63, 0, 1, 5));
    put(0, 2, rt_(1, 1, 2, 7));
    put(0, 3, it_(4, 1, 1, 2));
    rst_n = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (st_en) seen++;
    end
    chk("R9 no store from unknown", seen, 0);
    peek("R9 rt untouched", 1, 32'd3);
    peek("R9 rd untouched", 2, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_cmp();
    t_logic();
    t_mem();
    t_zero();
    t_nop();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule